// File: doc/BRIEF.md
# Page-Table Address Translation Unit

This block converts a processor virtual address into a physical address by consulting a single-level page table that lives in main memory. The incoming address is divided into two parts. The high-order bits are a virtual page number. The low-order bits are a byte offset inside the page. The page number is added to a table base register to locate one table entry. The unit reads that entry over a memory request/acknowledge port and examines its control bits. It then either produces the physical address, made of the entry's frame number followed by the untouched offset, or raises a page fault so that system software can bring the page in.

The unit also maintains the entry's dirty flag. If a store reaches a resident page whose modified flag is still clear, the unit writes the entry back to the table with that flag set, and only then reports completion. The base register is loaded through its own write strobe. Each translation captures the base value at the moment the translation is accepted, so reloading the register mid-walk cannot corrupt a walk that is already running.

Top module: `pt_xlate_unit`

## Requirements
- R1: After reset, `req_ready` is 1; `done`, `fault` and `mem_req` are 0; the base register holds 0.
- R2: For an accepted request, the unit issues a table read (`mem_req`=1, `mem_we`=0) at `mem_addr` = base + virtual page number (`req_vaddr[VA_W-1:OFF_W]`), taken modulo 2^MA_W. It holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack`, whatever the acknowledge latency.
- R3: If the entry's valid bit (bit 0) is 1, `done` pulses and `paddr` = {entry[PTE_W-1 -: FRAME_W], `req_vaddr[OFF_W-1:0]`} in that cycle.
- R4: If the entry's valid bit is 0, `fault` pulses instead of `done`, and no memory write is issued, for loads and stores alike.
- R5: A store (`req_write`=1) to a valid entry whose modified bit (bit 1) is 0 causes exactly one table write to the same entry address, with data equal to the fetched entry plus bit 1 set. This write completes before `done`.
- R6: A load, or a store to an entry whose modified bit is already 1, causes no table write.
- R7: A base register write (`base_we`) made while a translation is in progress leaves that translation on the previously latched base. The next translation uses the new value.
- R8: `req_ready` is 1 only while idle. Requests presented while busy are ignored and produce no result.
- R9: `done` and `fault` are never high together, and each lasts exactly one cycle per translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load strobe for the table base register |
| base_wdata | input | MA_W | New table base value |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Request is a store |
| req_ready | output | 1 | Unit idle and accepting a request |
| mem_req | output | 1 | Table access request, held until acknowledged |
| mem_we | output | 1 | Table access is a write |
| mem_addr | output | MA_W | Table entry address |
| mem_wdata | output | PTE_W | Entry value to write |
| mem_ack | input | 1 | Table access complete (one-cycle pulse) |
| mem_rdata | input | PTE_W | Entry value read, valid with mem_ack |
| done | output | 1 | Translation complete, paddr valid |
| fault | output | 1 | Page fault: entry not resident |
| paddr | output | FRAME_W+OFF_W | Physical address |

## Verification
The bench uses the default sizes: a 32-bit virtual address, a 12-bit offset, a 20-bit frame field and a 32-bit table address. With these sizes, a base value near the top of the table address space makes the entry-address sum wrap, and the offsets 0x000 and 0xFFF exercise both ends of the concatenation. The bench model memory has an acknowledge latency that can be adjusted between runs, from zero to several cycles. Long latencies open a window in which the base register can be reloaded and stray requests can be presented while a walk is in flight.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  // Control-bit positions inside a page-table entry.
  localparam int VALID_BIT = 0;
  localparam int MOD_BIT   = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_UPDATE,
    ST_DONE,
    ST_FAULT
  } walk_state_t;

endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int MA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_we,
  input  logic [MA_W-1:0] base_wdata,
  output logic [MA_W-1:0] base_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

endmodule

// File: rtl/pt_addr_path.sv
module pt_addr_path
  import pt_xlate_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20,
  parameter int PTE_W   = 32,
  parameter int MA_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic                     req_write,
  input  logic [MA_W-1:0]          base_q,
  input  logic                     pte_load,
  input  logic [PTE_W-1:0]         mem_rdata,
  output logic [MA_W-1:0]          ent_addr,
  output logic [PTE_W-1:0]         wb_data,
  output logic                     pte_valid,
  output logic                     pte_mod,
  output logic                     wr_lat,
  output logic [FRAME_W+OFF_W-1:0] paddr
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = FRAME_W + OFF_W;

  logic [VA_W-1:0]  va_lat;
  logic [MA_W-1:0]  base_lat;
  logic [PTE_W-1:0] pte_q;

  // Entry location: base plus page number, wrapping in the table address space.
  function automatic logic [MA_W-1:0] entry_addr(input logic [MA_W-1:0] b,
                                                 input logic [VPN_W-1:0] vpn);
    return b + MA_W'(vpn);
  endfunction

  // Physical address: frame field of the entry, then the page offset.
  function automatic logic [PA_W-1:0] phys_addr(input logic [PTE_W-1:0] pte,
                                                input logic [VA_W-1:0] va);
    return {pte[PTE_W-1 -: FRAME_W], va[OFF_W-1:0]};
  endfunction

  function automatic logic [PTE_W-1:0] mark_modified(input logic [PTE_W-1:0] pte);
    logic [PTE_W-1:0] t;
    t = pte;
    t[MOD_BIT] = 1'b1;
    return t;
  endfunction

  // Request capture: the base is sampled at acceptance (R7).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_lat   <= '0;
      base_lat <= '0;
      wr_lat   <= 1'b0;
    end else if (accept) begin
      va_lat   <= req_vaddr;
      base_lat <= base_q;
      wr_lat   <= req_write;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pte_q <= '0;
    else if (pte_load) pte_q <= mem_rdata;
  end

  assign ent_addr  = entry_addr(base_lat, va_lat[VA_W-1:OFF_W]);
  assign wb_data   = mark_modified(pte_q);
  assign pte_valid = pte_q[VALID_BIT];
  assign pte_mod   = pte_q[MOD_BIT];
  assign paddr     = phys_addr(pte_q, va_lat);

  // R7: the latched base only moves when a new request is taken.
  p_base_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && base_q != base_lat) |=> base_lat == $past(base_lat));

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_xlate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_ack,
  input  logic pte_valid,
  input  logic pte_mod,
  input  logic wr_lat,
  output logic req_ready,
  output logic accept,
  output logic pte_load,
  output logic mem_req,
  output logic mem_we,
  output logic done,
  output logic fault
);

  walk_state_t st, st_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE:   if (req_valid) st_nxt = ST_FETCH;
      ST_FETCH:  if (mem_ack)   st_nxt = ST_CHECK;
      ST_CHECK: begin
        if (!pte_valid)            st_nxt = ST_FAULT;
        else if (wr_lat && !pte_mod) st_nxt = ST_UPDATE;
        else                       st_nxt = ST_DONE;
      end
      ST_UPDATE: if (mem_ack)   st_nxt = ST_DONE;
      ST_DONE:   st_nxt = ST_IDLE;
      ST_FAULT:  st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign mem_req   = (st == ST_FETCH) || (st == ST_UPDATE);
  assign mem_we    = (st == ST_UPDATE);
  assign pte_load  = (st == ST_FETCH) && mem_ack;
  assign done      = (st == ST_DONE);
  assign fault     = (st == ST_FAULT);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_fault_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) fault |=> !fault);
  p_fetch_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_req && !mem_we));
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && mem_we == $past(mem_we)));
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
  p_update_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (wr_lat && pte_valid && !pte_mod));
  p_fault_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !pte_valid);
  p_done_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pte_valid);

endmodule

// File: rtl/pt_xlate_unit.sv
module pt_xlate_unit
  import pt_xlate_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20,
  parameter int PTE_W   = 32,
  parameter int MA_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     base_we,
  input  logic [MA_W-1:0]          base_wdata,
  input  logic                     req_valid,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic                     req_write,
  output logic                     req_ready,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [MA_W-1:0]          mem_addr,
  output logic [PTE_W-1:0]         mem_wdata,
  input  logic                     mem_ack,
  input  logic [PTE_W-1:0]         mem_rdata,
  output logic                     done,
  output logic                     fault,
  output logic [FRAME_W+OFF_W-1:0] paddr
);

  logic [MA_W-1:0] base_q;
  logic            accept;
  logic            pte_load;
  logic            pte_valid;
  logic            pte_mod;
  logic            wr_lat;

  pt_base_reg #(.MA_W(MA_W)) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_we    (base_we),
    .base_wdata (base_wdata),
    .base_q     (base_q)
  );

  pt_addr_path #(
    .VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .PTE_W(PTE_W), .MA_W(MA_W)
  ) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_vaddr (req_vaddr),
    .req_write (req_write),
    .base_q    (base_q),
    .pte_load  (pte_load),
    .mem_rdata (mem_rdata),
    .ent_addr  (mem_addr),
    .wb_data   (mem_wdata),
    .pte_valid (pte_valid),
    .pte_mod   (pte_mod),
    .wr_lat    (wr_lat),
    .paddr     (paddr)
  );

  pt_walk_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mem_ack   (mem_ack),
    .pte_valid (pte_valid),
    .pte_mod   (pte_mod),
    .wr_lat    (wr_lat),
    .req_ready (req_ready),
    .accept    (accept),
    .pte_load  (pte_load),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .done      (done),
    .fault     (fault)
  );

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr));
  p_wdata_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[MOD_BIT] && mem_wdata[VALID_BIT]));

endmodule

// File: tb/test_pt_xlate_unit.sv
module test_pt_xlate_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_ready, mem_req, mem_we, done, fault;
  logic [31:0] mem_addr, mem_wdata, paddr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_xlate_unit i_pt_xlate_unit (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_ready(req_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .fault(fault), .paddr(paddr)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench model of the page table memory.
  logic [31:0] pt_mem [logic [31:0]];
  int          lat = 0;
  int          wait_cnt = 0;
  int          wr_cnt = 0;
  logic [31:0] last_rd_addr = '0;
  logic [31:0] last_wr_addr = '0;
  logic [31:0] last_wr_data = '0;

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wait_cnt >= lat) begin
        mem_ack  <= 1'b1;
        wait_cnt <= 0;
        if (mem_we) begin
          pt_mem[mem_addr] = mem_wdata;
          wr_cnt       <= wr_cnt + 1;
          last_wr_addr <= mem_addr;
          last_wr_data <= mem_wdata;
        end else begin
          mem_rdata    <= pt_mem.exists(mem_addr) ? pt_mem[mem_addr] : 32'h0;
          last_rd_addr <= mem_addr;
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // Scoreboard.
  typedef struct {
    bit          is_fault;
    logic [31:0] pa;
    logic [31:0] ea;
    int          wr_delta;
    logic [31:0] wbdata;
  } exp_t;

  exp_t        expq[$];
  string       tagq[$];
  logic [31:0] base_model = '0;
  int          wr_seen = 0;

  function automatic logic [31:0] mkpte(input logic [19:0] frame, input bit m, input bit v);
    return {frame, 10'd0, m, v};
  endfunction

  task automatic xlate(input logic [31:0] va, input bit wr, input string tag,
                       input bit wait_result);
    exp_t        e;
    logic [31:0] pte;
    while (!req_ready) @(negedge clk);
    e.ea       = base_model + {12'd0, va[31:12]};
    pte        = pt_mem.exists(e.ea) ? pt_mem[e.ea] : 32'h0;
    e.is_fault = !pte[0];
    e.pa       = {pte[31:12], va[11:0]};
    e.wr_delta = (pte[0] && wr && !pte[1]) ? 1 : 0;
    e.wbdata   = pte | 32'h2;
    expq.push_back(e);
    tagq.push_back(tag);
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    if (wait_result) while (expq.size() != 0) @(negedge clk);
  endtask

  task automatic set_base(input logic [31:0] b);
    base_we    = 1'b1;
    base_wdata = b;
    @(negedge clk);
    base_we    = 1'b0;
    base_model = b;
  endtask

  bit prev_result = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_result)
        check(!(done || fault), "R9 pulse width", {30'd0, done, fault}, 32'h0);
      if (done || fault) begin
        check(!(done && fault), "R9 exclusive", {30'd0, done, fault}, 32'h0);
        if (expq.size() == 0) begin
          check(1'b0, "R8 unexpected result", paddr, 32'h0);
        end else begin
          exp_t  e;
          string t;
          int    d;
          e = expq.pop_front();
          t = tagq.pop_front();
          d = wr_cnt - wr_seen;
          wr_seen = wr_cnt;
          check(last_rd_addr == e.ea, {t, " R2 entry address"}, last_rd_addr, e.ea);
          if (e.is_fault) begin
            check(fault && !done, {t, " R4 fault"}, {31'd0, fault}, 32'h1);
            check(d == 0, {t, " R4 no write"}, d, 0);
          end else begin
            check(done && !fault, {t, " R3 done"}, {31'd0, done}, 32'h1);
            check(paddr == e.pa, {t, " R3 paddr"}, paddr, e.pa);
            check(d == e.wr_delta, {t, " R5/R6 write count"}, d, e.wr_delta);
            if (e.wr_delta == 1) begin
              check(last_wr_addr == e.ea, {t, " R5 write address"}, last_wr_addr, e.ea);
              check(last_wr_data == e.wbdata, {t, " R5 write data"}, last_wr_data, e.wbdata);
            end
          end
        end
      end
      prev_result = done || fault;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'h1);
    check(!done && !fault, "R1 outputs", {30'd0, done, fault}, 32'h0);
    check(mem_req == 1'b0, "R1 mem_req", {31'd0, mem_req}, 32'h0);

    // R1: base resets to 0, so the entry address equals the page number.
    pt_mem[32'h0000_0012] = mkpte(20'hABCDE, 1'b0, 1'b1);
    xlate(32'h0001_2345, 1'b0, "R1 base", 1'b1);

    set_base(32'h0000_1000);
    pt_mem[32'h0000_1005] = mkpte(20'h12345, 1'b0, 1'b1);
    pt_mem[32'h0000_1006] = mkpte(20'h55555, 1'b1, 1'b0);
    pt_mem[32'h0000_1007] = mkpte(20'h0F0F0, 1'b1, 1'b1);
    xlate(32'h0000_5000, 1'b0, "R3 off0", 1'b1);
    xlate(32'h0000_5FFF, 1'b0, "R3 offmax", 1'b1);
    xlate(32'h0000_5ABC, 1'b0, "R6 load clean", 1'b1);
    xlate(32'h0000_6123, 1'b0, "R4 load", 1'b1);
    xlate(32'h0000_6123, 1'b1, "R4 store", 1'b1);
    xlate(32'h0000_8000, 1'b0, "R4 absent", 1'b1);
    xlate(32'h0000_5444, 1'b1, "R5 store clean", 1'b1);
    xlate(32'h0000_5444, 1'b1, "R6 store dirty", 1'b1);
    xlate(32'h0000_7321, 1'b1, "R6 store premod", 1'b1);

    // R2: longer handshake latency.
    lat = 4;
    pt_mem[32'h0000_1009] = mkpte(20'h00AAA, 1'b0, 1'b1);
    xlate(32'h0000_9876, 1'b1, "R2 latency", 1'b1);
    lat = 2;
    set_base(32'hFFFF_FFF0);
    pt_mem[32'h0000_0010] = mkpte(20'hBEEF0, 1'b0, 1'b1);
    xlate(32'h0002_0ACE, 1'b0, "R2 wrap", 1'b1);

    // R7: base reload during a walk.
    lat = 6;
    set_base(32'h0000_2000);
    pt_mem[32'h0000_2003] = mkpte(20'h11111, 1'b0, 1'b1);
    pt_mem[32'h0000_3003] = mkpte(20'h22222, 1'b0, 1'b1);
    xlate(32'h0000_3010, 1'b0, "R7 old base", 1'b0);
    set_base(32'h0000_3000);
    while (expq.size() != 0) @(negedge clk);
    xlate(32'h0000_3020, 1'b0, "R7 new base", 1'b1);

    // R8: requests while busy are ignored.
    xlate(32'h0000_3040, 1'b0, "R8 first", 1'b0);
    for (int i = 0; i < 3; i++) begin
      req_valid = 1'b1;
      req_vaddr = 32'h0000_4777;
      req_write = 1'b1;
      check(req_ready == 1'b0, "R8 busy ready", {31'd0, req_ready}, 32'h0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(wr_cnt == wr_seen, "R8 no stray write", wr_cnt, wr_seen);
    check(req_ready == 1'b1, "R8 idle ready", {31'd0, req_ready}, 32'h1);

    lat = 0;
    xlate(32'h0000_3FFF, 1'b1, "R5 zero latency", 1'b1);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule